// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This block walks a ring of transmit descriptors kept in system memory. Software programs the ring's base address, fills descriptors and hands each one to hardware by setting its ownership flag. When a poll is triggered, the poller reads the control word of the current descriptor through a simple word-wide memory request/acknowledge port. If hardware owns that descriptor, the poller reads the rest of it and passes the buffer address, frame length and frame-boundary flags to a downstream frame mover as a job. When the mover signals completion, the poller writes the low control word back with ownership returned to software and the collision status filled in. It then moves to the next descriptor and keeps going until it meets one that software still owns.

A poll is started either by a one-cycle poll-demand pulse or by an optional periodic timer. The timer period is a 4-bit multiple of a poll cycle. That cycle has a normal and a long length, and the 10 Mb/s line rate stretches it by ten. The ring has no fixed size: a flag in each descriptor marks the last one, and after that descriptor the walk returns to the base.

Each descriptor takes 16 bytes. The word at offset 0 holds control bits 31:0 (bit 31 ownership, bits 1:0 collision status). The word at offset 4 holds control bits 63:32 (bit 31 end of ring, bit 28 first of frame, bit 27 last of frame, bits 10:0 length). The word at offset 8 holds the buffer address.

Top module: `tx_ring_poller`

## Requirements
- R1: After reset the poller is idle: `mem_req` and `job_valid` are low.
- R2: On a trigger with `dma_en` high, the poller reads the control word at offset 0 of the current descriptor. If bit 31 of that word is 1 (hardware owned), it reads offsets 4 and 8 and raises `job_valid` with `job_buf` equal to the offset-8 word, `job_len` equal to bits 10:0 of the offset-4 word, and `job_first`/`job_last` equal to bits 28/27 of the offset-4 word. These values hold until `job_done`.
- R3: After `job_done`, the poller writes only the offset-0 word, with bit 31 cleared, bits 1:0 set to `job_col`, and bits 30:2 unchanged. The offset-4 word, including the end-of-ring flag, is never written.
- R4: After the write-back, the poller goes on to the descriptor 16 bytes further on without a new trigger.
- R5: If bit 31 of the offset-4 word was set, the next descriptor read after the write-back is at the ring base (`ring_base` with bits 3:0 forced to zero).
- R6: If the offset-0 word has bit 31 clear, the poller issues no job and goes idle without advancing, so the next trigger reads the same descriptor again.
- R7: With `poll_n` nonzero and `dma_en` high, the automatic timer starts a poll every `poll_n` poll cycles. With `poll_n` equal to 0, it never starts one.
- R8: A poll cycle lasts UNIT_TICKS clocks when `poll_long`=0 and `rate_100`=1. `poll_long`=1 multiplies it by 16 and `rate_100`=0 multiplies it by 10.
- R9: While `dma_en` is low, triggers start no reads. On each rising edge of `dma_en`, the current pointer is set to the ring base (the pointer is zero after reset).
- R10: A trigger that arrives while the poller is busy is remembered, and it starts one more poll once the poller goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | Transmit fetch enable; its rising edge rewinds to the base |
| ring_base | input | ADDR_W | Ring base byte address (bits 3:0 ignored) |
| poll_kick | input | 1 | One-cycle poll-demand pulse |
| poll_n | input | 4 | Auto-poll interval in poll cycles, 0 = off |
| poll_long | input | 1 | Selects the long poll cycle |
| rate_100 | input | 1 | 1 = 100 Mb/s cycle length, 0 = 10 Mb/s |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the request |
| job_valid | output | 1 | Frame job pending, held until `job_done` |
| job_buf | output | ADDR_W | Buffer address of the job |
| job_len | output | 11 | Frame length in bytes |
| job_first | output | 1 | Descriptor starts a frame |
| job_last | output | 1 | Descriptor ends a frame |
| job_done | input | 1 | One-cycle completion of the job |
| job_col | input | 2 | Collision status reported with `job_done` |

## Verification
The hardest case to reach is a poll demand that lands while a descriptor is in flight. Without the remembered trigger it would vanish, and nothing at the ports would show it, because the walk goes on by itself anyway. The bench waits until it sees `job_valid`, pulses `poll_kick` in the middle of the job, and leaves the following descriptor owned by software. The only sign that the trigger was kept is a second read of that descriptor after the poller has gone idle. The timer periods are checked by timing the gap between successive control-word reads on a ring that software owns entirely.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 11;
  localparam int COL_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CTRL, ST_RD_FLAGS, ST_RD_BUF, ST_JOB, ST_WRBACK
  } walk_state_t;

  // ownership flag in the low control word
  function automatic logic hw_owned(input logic [WORD_W-1:0] lo);
    return lo[31];
  endfunction

  // low control word as written back: owner cleared, status inserted
  function automatic logic [WORD_W-1:0] wrback_word(input logic [WORD_W-1:0] lo,
                                                    input logic [COL_W-1:0] col);
    return {1'b0, lo[30:COL_W], col};
  endfunction

  // poll cycle in clocks for the selected length and line rate
  function automatic int unsigned cycle_ticks(input int unsigned unit,
                                              input logic long_sel,
                                              input logic fast);
    int unsigned t;
    t = long_sel ? unit * 16 : unit;
    return fast ? t : t * 10;
  endfunction

endpackage

// File: rtl/tx_poll_timer.sv
module tx_poll_timer #(
  parameter int UNIT_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] poll_n,
  input  logic       poll_long,
  input  logic       rate_100,
  output logic       fire
);
  import tx_ring_pkg::*;

  localparam int MAX_TICKS = UNIT_TICKS * 160;
  localparam int TICK_W    = $clog2(MAX_TICKS + 1);

  logic [TICK_W-1:0] tick_q;
  logic [3:0]        cyc_q;
  logic [TICK_W-1:0] tick_last;
  logic              enabled;
  logic              tick_end;

  assign tick_last = TICK_W'(cycle_ticks(UNIT_TICKS, poll_long, rate_100) - 1);
  assign enabled   = run && (poll_n != 4'd0);
  assign tick_end  = tick_q >= tick_last;
  assign fire      = enabled && tick_end && (cyc_q >= poll_n - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      cyc_q  <= '0;
    end else if (!enabled) begin
      tick_q <= '0;
      cyc_q  <= '0;
    end else if (tick_end) begin
      tick_q <= '0;
      cyc_q  <= fire ? 4'd0 : cyc_q + 4'd1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  // spacing check: with settings unchanged since the last fire, the gap is n cycles
  logic [31:0] gap_q;
  logic        armed_q;
  logic [5:0]  cfg_q;
  logic [31:0] period_now;
  assign period_now = 32'(poll_n) * cycle_ticks(UNIT_TICKS, poll_long, rate_100);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
      cfg_q   <= '0;
    end else begin
      cfg_q <= {poll_n, poll_long, rate_100};
      if (fire) begin
        gap_q   <= 32'd1;
        armed_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 32'd1;
        if (cfg_q != {poll_n, poll_long, rate_100} || !run) armed_q <= 1'b0;
      end
    end
  end

  p_fire_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && armed_q && cfg_q == {poll_n, poll_long, rate_100}) |-> gap_q == period_now);

  p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_n == 4'd0) |=> (poll_n != 4'd0) || !fire);

endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dma_en,
  input  logic [ADDR_W-1:0]             ring_base,
  input  logic                          trig,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [tx_ring_pkg::WORD_W-1:0] mem_wdata,
  input  logic [tx_ring_pkg::WORD_W-1:0] mem_rdata,
  input  logic                          mem_ack,
  output logic                          job_valid,
  output logic [ADDR_W-1:0]             job_buf,
  output logic [tx_ring_pkg::LEN_W-1:0] job_len,
  output logic                          job_first,
  output logic                          job_last,
  input  logic                          job_done,
  input  logic [tx_ring_pkg::COL_W-1:0] job_col
);
  import tx_ring_pkg::*;

  localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~ADDR_W'(15);

  walk_state_t        st_q;
  logic [ADDR_W-1:0]  ptr_q, desc_q, buf_q;
  logic [WORD_W-1:0]  lo_q;
  logic               end_q, first_q, last_q, pend_q, dma_q;
  logic [LEN_W-1:0]   len_q;
  logic [COL_W-1:0]   col_q;

  // named internal events
  logic              dma_rise, ev_start, ev_stop, ev_wb_done;
  logic [ADDR_W-1:0] base_al, next_desc, start_addr;

  assign base_al    = ring_base & BASE_MASK;
  assign dma_rise   = dma_en && !dma_q;
  assign start_addr = dma_rise ? base_al : ptr_q;
  assign next_desc  = end_q ? base_al : desc_q + DESC_STEP;
  assign ev_start   = (st_q == ST_IDLE) && dma_en && (trig || pend_q);
  assign ev_stop    = (st_q == ST_RD_CTRL) && mem_ack && !hw_owned(mem_rdata);
  assign ev_wb_done = (st_q == ST_WRBACK) && mem_ack;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_q;
    mem_wdata = '0;
    unique case (st_q)
      ST_RD_CTRL:  mem_req = 1'b1;
      ST_RD_FLAGS: begin mem_req = 1'b1; mem_addr = desc_q + ADDR_W'(4); end
      ST_RD_BUF:   begin mem_req = 1'b1; mem_addr = desc_q + ADDR_W'(8); end
      ST_WRBACK:   begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = wrback_word(lo_q, col_q); end
      default: ;
    endcase
  end

  assign job_valid = (st_q == ST_JOB);
  assign job_buf   = buf_q;
  assign job_len   = len_q;
  assign job_first = first_q;
  assign job_last  = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ptr_q <= '0; desc_q <= '0; buf_q <= '0; lo_q <= '0;
      end_q <= 1'b0; first_q <= 1'b0; last_q <= 1'b0; len_q <= '0;
      col_q <= '0; pend_q <= 1'b0; dma_q <= 1'b0;
    end else begin
      dma_q <= dma_en;
      if (dma_rise) ptr_q <= base_al;
      if (st_q != ST_IDLE && trig) pend_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (ev_start) begin
          desc_q <= start_addr;
          pend_q <= 1'b0;
          st_q   <= ST_RD_CTRL;
        end
        ST_RD_CTRL: if (mem_ack) begin
          lo_q <= mem_rdata;
          st_q <= hw_owned(mem_rdata) ? ST_RD_FLAGS : ST_IDLE;
        end
        ST_RD_FLAGS: if (mem_ack) begin
          end_q   <= mem_rdata[31];
          first_q <= mem_rdata[28];
          last_q  <= mem_rdata[27];
          len_q   <= mem_rdata[LEN_W-1:0];
          st_q    <= ST_RD_BUF;
        end
        ST_RD_BUF: if (mem_ack) begin
          buf_q <= ADDR_W'(mem_rdata);
          st_q  <= ST_JOB;
        end
        ST_JOB: if (job_done) begin
          col_q <= job_col;
          st_q  <= ST_WRBACK;
        end
        ST_WRBACK: if (mem_ack) begin
          if (!dma_rise) ptr_q <= next_desc;
          desc_q <= next_desc;
          st_q   <= dma_en ? ST_RD_CTRL : ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_job_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(job_valid) |-> lo_q[31]);

  p_job_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && !job_done) |=> job_valid && $stable(job_buf) && $stable(job_len));

  p_wb_owner_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[31] && mem_addr[3:0] == 4'd0);

  p_wrap_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wb_done && end_q && !dma_rise) |=> ptr_q == $past(base_al));

  p_stop_no_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !dma_rise) |=> $stable(ptr_q) && st_q == ST_IDLE);

  p_off_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !dma_en) |=> st_q == ST_IDLE);

endmodule

// File: rtl/tx_ring_poller.sv
module tx_ring_poller #(
  parameter int ADDR_W     = 32,
  parameter int UNIT_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              poll_kick,
  input  logic [3:0]        poll_n,
  input  logic              poll_long,
  input  logic              rate_100,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              job_valid,
  output logic [ADDR_W-1:0] job_buf,
  output logic [10:0]       job_len,
  output logic              job_first,
  output logic              job_last,
  input  logic              job_done,
  input  logic [1:0]        job_col
);

  logic timer_fire;
  logic trig;

  tx_poll_timer #(.UNIT_TICKS(UNIT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(dma_en), .poll_n(poll_n),
    .poll_long(poll_long), .rate_100(rate_100), .fire(timer_fire)
  );

  assign trig = poll_kick || timer_fire;

  tx_ring_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .ring_base(ring_base), .trig(trig),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .job_valid(job_valid), .job_buf(job_buf), .job_len(job_len),
    .job_first(job_first), .job_last(job_last), .job_done(job_done), .job_col(job_col)
  );

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !mem_req && !job_valid);

endmodule

// File: tb/tx_ring_poller_test.sv
module tx_ring_poller_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_en = 1'b0;
  logic [31:0] ring_base = 32'h20;
  logic        poll_kick = 1'b0;
  logic [3:0]  poll_n = 4'd0;
  logic        poll_long = 1'b0;
  logic        rate_100 = 1'b1;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        job_valid, job_first, job_last, job_done;
  logic [31:0] job_buf;
  logic [10:0] job_len;
  logic [1:0]  job_col;

  always #2 clk = ~clk;

  tx_ring_poller #(.ADDR_W(32), .UNIT_TICKS(8)) uut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .ring_base(ring_base),
    .poll_kick(poll_kick), .poll_n(poll_n), .poll_long(poll_long), .rate_100(rate_100),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .job_valid(job_valid), .job_buf(job_buf), .job_len(job_len),
    .job_first(job_first), .job_last(job_last), .job_done(job_done), .job_col(job_col)
  );

  int n_tests = 0, n_fail = 0;
  logic [31:0] mem [64];
  int          wr_n = 0;
  logic [31:0] rd_log [1024];
  int          rd_n = 0;
  longint      cyc = 0, t_last = 0, t_prev = 0;
  logic [31:0] jb_buf [64];
  logic [10:0] jb_len [64];
  logic [1:0]  jb_fl [64];
  int          jb_n = 0;
  logic [1:0]  col_set = 2'b10;

  // behavioural memory, one-cycle acknowledge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:2]];
      if (mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wr_n <= wr_n + 1;
      end
    end
    if (mem_req && mem_ack && !mem_we && mem_addr[3:0] == 4'd0) begin
      rd_log[rd_n] <= mem_addr;
      rd_n   <= rd_n + 1;
      t_prev <= t_last;
      t_last <= cyc;
    end
  end

  // frame mover stand-in
  initial begin
    job_done = 1'b0;
    job_col  = 2'b00;
    forever begin
      @(negedge clk);
      if (job_valid && !job_done) begin
        jb_buf[jb_n] = job_buf;
        jb_len[jb_n] = job_len;
        jb_fl[jb_n]  = {job_first, job_last};
        jb_n++;
        repeat (4) @(negedge clk);
        job_done = 1'b1;
        job_col  = col_set;
        @(negedge clk);
        job_done = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input bit own, input bit last_ring, input bit f,
                          input bit l, input int len, input logic [31:0] bufa, input logic [31:0] lo_bits);
    mem[a/4]     = {own, lo_bits[30:0]};
    mem[a/4 + 1] = {last_ring, 2'b00, f, l, 16'h0, len[10:0]};
    mem[a/4 + 2] = bufa;
  endtask

  task automatic kick();
    @(negedge clk); poll_kick = 1'b1;
    @(negedge clk); poll_kick = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
    chk(job_valid == 1'b0, "R1 job_valid", 32'(job_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); dma_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_basic();
    int r0, j0;
    put_desc(32'h20, 1, 0, 1, 1, 100, 32'h1000, 32'h1234_5671);
    put_desc(32'h30, 0, 0, 0, 0, 0, 0, 0);
    r0 = rd_n; j0 = jb_n;
    kick(); repeat (40) @(negedge clk);
    chk(jb_n == j0 + 1, "R2 job count", 32'(jb_n - j0), 1);
    chk(jb_buf[j0] == 32'h1000, "R2 buffer", jb_buf[j0], 32'h1000);
    chk(jb_len[j0] == 11'd100, "R2 length", 32'(jb_len[j0]), 100);
    chk(jb_fl[j0] == 2'b11, "R2 first/last", 32'(jb_fl[j0]), 3);
    chk(mem[8] == ((32'h1234_5671 & 32'h7FFF_FFFC) | 32'h2), "R3 writeback", mem[8], (32'h1234_5671 & 32'h7FFF_FFFC) | 32'h2);
    chk(mem[9] == 32'h1800_0064, "R3 upper word kept", mem[9], 32'h1800_0064);
    chk(rd_n == r0 + 2 && rd_log[r0 + 1] == 32'h30, "R4 next descriptor", rd_log[r0 + 1], 32'h30);
    r0 = rd_n;
    kick(); repeat (20) @(negedge clk);
    chk(rd_n == r0 + 1 && rd_log[r0] == 32'h30, "R6 same descriptor reread", rd_log[r0], 32'h30);
    chk(jb_n == j0 + 1, "R6 no job when sw owned", 32'(jb_n - j0), 1);
  endtask

  task automatic t_dma();
    int r0;
    dma_en = 1'b0;
    r0 = rd_n;
    kick(); repeat (20) @(negedge clk);
    chk(rd_n == r0, "R9 no fetch while disabled", 32'(rd_n - r0), 0);
    put_desc(32'h20, 0, 0, 0, 0, 0, 0, 0);
    dma_en = 1'b1;
    repeat (2) @(negedge clk);
    kick(); repeat (20) @(negedge clk);
    chk(rd_n == r0 + 1 && rd_log[r0] == 32'h20, "R9 rewind to base", rd_log[r0], 32'h20);
  endtask

  task automatic t_wrap();
    int r0, j0;
    put_desc(32'h20, 1, 0, 1, 0, 200, 32'h2000, 0);
    put_desc(32'h30, 1, 0, 0, 0, 300, 32'h3000, 0);
    put_desc(32'h40, 1, 1, 0, 1, 50,  32'h4000, 0);
    r0 = rd_n; j0 = jb_n;
    col_set = 2'b01;
    kick(); repeat (120) @(negedge clk);
    chk(jb_n == j0 + 3, "R4 three jobs", 32'(jb_n - j0), 3);
    chk(jb_fl[j0] == 2'b10 && jb_fl[j0 + 2] == 2'b01, "R2 frame flags", 32'({jb_fl[j0], jb_fl[j0 + 2]}), 32'h9);
    chk(jb_len[j0 + 1] == 11'd300 && jb_buf[j0 + 1] == 32'h3000, "R2 middle job", 32'(jb_len[j0 + 1]), 300);
    chk(rd_n == r0 + 4 && rd_log[r0 + 3] == 32'h20, "R5 wrap to base", rd_log[r0 + 3], 32'h20);
    chk(mem[17] == 32'h8800_0032, "R3 end flag kept", mem[17], 32'h8800_0032);
    chk(mem[16] == 32'h1, "R3 status bits", mem[16], 32'h1);
  endtask

  task automatic t_pending();
    int r0;
    put_desc(32'h20, 1, 0, 1, 1, 64, 32'h5000, 0);
    put_desc(32'h30, 0, 0, 0, 0, 0, 0, 0);
    r0 = rd_n;
    kick();
    while (!job_valid) @(negedge clk);
    kick();
    repeat (60) @(negedge clk);
    chk(rd_n == r0 + 3, "R10 held trigger refetch", 32'(rd_n - r0), 3);
    chk(rd_log[r0 + 2] == 32'h30, "R10 refetch address", rd_log[r0 + 2], 32'h30);
  endtask

  task automatic t_period(input logic [3:0] n, input bit lng, input bit fast, input int exp);
    poll_n = n; poll_long = lng; rate_100 = fast;
    repeat (3 * exp + 20) @(negedge clk);
    chk(t_last - t_prev == longint'(exp), "R8 poll interval", 32'(t_last - t_prev), 32'(exp));
  endtask

  task automatic t_auto();
    int r0;
    t_period(4'd2, 1'b0, 1'b1, 16);
    t_period(4'd1, 1'b1, 1'b1, 128);
    t_period(4'd1, 1'b0, 1'b0, 80);
    t_period(4'd3, 1'b0, 1'b0, 240);
    poll_n = 4'd0;
    repeat (4) @(negedge clk);
    r0 = rd_n;
    repeat (400) @(negedge clk);
    chk(rd_n == r0, "R7 auto poll off", 32'(rd_n - r0), 0);
    chk(t_last > 0, "R7 auto poll fired", 32'(t_last), 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    t_reset();
    t_basic();
    t_dma();
    t_wrap();
    t_pending();
    t_auto();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule